// File: doc/BRIEF.md
# Data Operand Fetch Unit with Auxiliary Register Post-Modify

This block is the operand fetch stage of a 16-bit fixed-point signal processor. When an instruction is issued, it takes the low opcode byte and forms a data memory address. The address is either direct, built from the current data page and a 7-bit offset, or indirect, taken from the auxiliary register that the pointer currently selects. It reads the 16-bit word at that address and widens it to 32 bits, by zero fill or by sign fill as the instruction asks. It then shifts the widened word left by a 4-bit count and presents the result to the accumulator path as a single-cycle valid pulse.

In indirect mode the selected auxiliary register can be stepped up or down once the address has been taken. Only its low 9 bits change. The one-bit pointer can also be reloaded from the opcode. A load-register variant writes the raw fetched word into the auxiliary register that the major opcode names. If that register is the one the pointer selects, the load wins and the step is skipped.

The unit runs as a three-state machine. In IDLE it accepts an issue. In ADDR it drives the memory read. In LOAD it takes the returned word, registers the operand and commits the register updates. The transitions are IDLE to ADDR on an accepted issue, ADDR to LOAD always, and LOAD to IDLE always. The memory returns data one cycle after the read strobe.

Top module: `opnd_fetch`

## Requirements
- R1: After reset, busy, mem_rd and opnd_vld are 0, opnd is 0, both auxiliary registers are 0 and arp is 0.
- R2: With issue_op[7]=0, mem_addr in the cycle after acceptance equals {issue_dp, issue_op[6:0]} and mem_rd is 1.
- R3: With issue_op[7]=1, mem_addr equals the low 8 bits of the auxiliary register that arp selects, as it stood before this instruction's update.
- R4: With issue_sx=0 the word is zero-extended to 32 bits. With issue_sx=1 bit 15 is copied into bits 31:16.
- R5: opnd equals the extended word shifted left by issue_shift (0..15), truncated to 32 bits. opnd_vld is a one-cycle pulse asserted two clock edges after the issue is accepted.
- R6: In indirect mode, opcode bit 5 adds 1 and bit 4 subtracts 1 (both set gives no net change). The step wraps in bits 8:0, and bits 15:9 of the register are kept.
- R7: In indirect mode with opcode bit 3 = 0, arp takes opcode bit 0. Register and pointer updates take effect on the same edge as opnd_vld. Direct mode changes neither.
- R8: With issue_lar=1, the auxiliary register selected by issue_tgt (0 or 1) takes the raw fetched word. If indirect mode is used and issue_tgt equals the current arp, the step is skipped. Otherwise the step applies to the register arp selects.
- R9: busy is 1 for the two cycles after acceptance. An issue presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Start an operand fetch (taken only when not busy) |
| issue_op | input | 8 | Low opcode byte: addressing mode, offset, step and pointer fields |
| issue_lar | input | 1 | Load-auxiliary-register variant |
| issue_tgt | input | 1 | Target auxiliary register for the load variant |
| issue_sx | input | 1 | Sign-extend request |
| issue_shift | input | 4 | Left shift count |
| issue_dp | input | 1 | Data page for direct addressing |
| busy | output | 1 | Fetch in progress |
| mem_rd | output | 1 | Data memory read strobe |
| mem_addr | output | 8 | Data memory address |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| opnd | output | 32 | Extended, shifted operand |
| opnd_vld | output | 1 | Operand valid pulse |
| ar_bank | output | 32 | Auxiliary registers, register 1 in bits 31:16 |
| arp | output | 1 | Auxiliary register pointer |

## Verification
Two events can land on the same register in the LOAD cycle: a load of the fetched word and a post-step of the pointer-selected register. The bench provokes this by issuing load-variant opcodes in indirect mode with the step bits set. It does this both with the target equal to the current pointer and with the target different from it, while also reloading the pointer. Each result is compared against a model that applies the load-wins rule, steps only the other register, and switches the pointer after the address has been taken.

// File: rtl/opnd_fetch_pkg.sv
package opnd_fetch_pkg;
    localparam int ARP_W = 1;
    localparam int AR_N  = 1 << ARP_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LOAD = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/opnd_fetch_agen.sv
module opnd_fetch_agen #(
    parameter int OFS_W = 7,
    parameter int DP_W  = 1,
    localparam int ADDR_W = DP_W + OFS_W
) (
    input  logic              ind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DP_W-1:0]   dpage,
    input  logic [ADDR_W-1:0] ar_addr,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        if (ind) addr = ar_addr;
        else     addr = {dpage, ofs};
    end
endmodule

// File: rtl/opnd_fetch_xsh.sv
module opnd_fetch_xsh #(
    parameter int DATA_W = 16,
    parameter int SH_W   = 4,
    parameter int OUT_W  = 32,
    localparam int PAD_W = OUT_W - DATA_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic              sx,
    input  logic [SH_W-1:0]   sh,
    output logic [OUT_W-1:0]  result
);
    logic [OUT_W-1:0] wide;

    always_comb begin
        wide   = sx ? {{PAD_W{word[DATA_W-1]}}, word} : {{PAD_W{1'b0}}, word};
        result = wide << sh;
    end
endmodule

// File: rtl/opnd_fetch_arf.sv
module opnd_fetch_arf
    import opnd_fetch_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MOD_W  = 9,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mod_en,
    input  logic                     step_up,
    input  logic                     step_dn,
    input  logic                     ptr_ld,
    input  logic [ARP_W-1:0]         ptr_val,
    input  logic                     ld_en,
    input  logic [ARP_W-1:0]         ld_sel,
    input  logic [DATA_W-1:0]        ld_data,
    output logic [ADDR_W-1:0]        cur_addr,
    output logic [AR_N*DATA_W-1:0]   ar_flat,
    output logic [ARP_W-1:0]         ptr
);
    logic [DATA_W-1:0] ar_q [AR_N];
    logic [ARP_W-1:0]  ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (ptr_ld) ptr_q <= ptr_val;
    end

    for (genvar i = 0; i < AR_N; i++) begin : g_ar
        logic [MOD_W-1:0] stepped;
        always_comb begin
            stepped = ar_q[i][MOD_W-1:0]
                    + {{(MOD_W-1){1'b0}}, step_up}
                    - {{(MOD_W-1){1'b0}}, step_dn};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ar_q[i] <= '0;
            else if (ld_en && (ld_sel == ARP_W'(i)))
                ar_q[i] <= ld_data;
            else if (mod_en && (ptr_q == ARP_W'(i)))
                ar_q[i] <= {ar_q[i][DATA_W-1:MOD_W], stepped};
        end

        assign ar_flat[i*DATA_W +: DATA_W] = ar_q[i];
    end

    assign cur_addr = ar_q[ptr_q][ADDR_W-1:0];
    assign ptr      = ptr_q;
endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
    import opnd_fetch_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 7,
    parameter int DP_W   = 1,
    parameter int MOD_W  = 9,
    parameter int SH_W   = 4,
    parameter int OUT_W  = 32,
    localparam int ADDR_W = DP_W + OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue,
    input  logic [7:0]             issue_op,
    input  logic                   issue_lar,
    input  logic                   issue_tgt,
    input  logic                   issue_sx,
    input  logic [SH_W-1:0]        issue_shift,
    input  logic [DP_W-1:0]        issue_dp,
    output logic                   busy,
    output logic                   mem_rd,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic [OUT_W-1:0]       opnd,
    output logic                   opnd_vld,
    output logic [AR_N*DATA_W-1:0] ar_bank,
    output logic                   arp
);
    fetch_st_e st_q, st_d;

    logic              ind_q, up_q, dn_q, keep_ptr_q, ptr_bit_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              lar_q, tgt_q, sx_q;
    logic [SH_W-1:0]   sh_q;
    logic [DP_W-1:0]   dp_q;
    logic              accept, commit;
    logic [ADDR_W-1:0] cur_addr;
    logic [OUT_W-1:0]  shifted;
    logic [OUT_W-1:0]  opnd_q;
    logic              vld_q;
    logic [ARP_W-1:0]  ptr;

    assign accept = issue && (st_q == ST_IDLE);
    assign commit = (st_q == ST_LOAD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (issue) st_d = ST_ADDR;
            ST_ADDR: st_d = ST_LOAD;
            ST_LOAD: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy   = 1'b0;
        mem_rd = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_ADDR: begin busy = 1'b1; mem_rd = 1'b1; end
            ST_LOAD: busy = 1'b1;
            default: ;
        endcase
    end

    // instruction fields, captured on acceptance only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ind_q <= 1'b0; up_q <= 1'b0; dn_q <= 1'b0;
            keep_ptr_q <= 1'b1; ptr_bit_q <= 1'b0;
            ofs_q <= '0; lar_q <= 1'b0; tgt_q <= 1'b0;
            sx_q <= 1'b0; sh_q <= '0; dp_q <= '0;
        end else if (accept) begin
            ind_q      <= issue_op[7];
            ofs_q      <= issue_op[OFS_W-1:0];
            up_q       <= issue_op[5];
            dn_q       <= issue_op[4];
            keep_ptr_q <= issue_op[3];
            ptr_bit_q  <= issue_op[0];
            lar_q      <= issue_lar;
            tgt_q      <= issue_tgt;
            sx_q       <= issue_sx;
            sh_q       <= issue_shift;
            dp_q       <= issue_dp;
        end
    end

    opnd_fetch_agen #(.OFS_W(OFS_W), .DP_W(DP_W)) agen_i (
        .ind     (ind_q),
        .ofs     (ofs_q),
        .dpage   (dp_q),
        .ar_addr (cur_addr),
        .addr    (mem_addr)
    );

    opnd_fetch_xsh #(.DATA_W(DATA_W), .SH_W(SH_W), .OUT_W(OUT_W)) xsh_i (
        .word   (mem_rdata),
        .sx     (sx_q),
        .sh     (sh_q),
        .result (shifted)
    );

    opnd_fetch_arf #(.DATA_W(DATA_W), .MOD_W(MOD_W), .ADDR_W(ADDR_W)) arf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (commit && ind_q),
        .step_up  (up_q),
        .step_dn  (dn_q),
        .ptr_ld   (commit && ind_q && !keep_ptr_q),
        .ptr_val  (ptr_bit_q),
        .ld_en    (commit && lar_q),
        .ld_sel   (tgt_q),
        .ld_data  (mem_rdata),
        .cur_addr (cur_addr),
        .ar_flat  (ar_bank),
        .ptr      (ptr)
    );

    // operand register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= commit;
            if (commit) opnd_q <= shifted;
        end
    end

    assign opnd     = opnd_q;
    assign opnd_vld = vld_q;
    assign arp      = ptr;
endmodule

// File: rtl/opnd_fetch_chk.sv
module opnd_fetch_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd,
    input logic              opnd_vld,
    input logic [2*DATA_W-1:0] ar_bank,
    input logic              arp,
    input logic              lar_q
);
    AST_VLD_TWO_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ##2 opnd_vld); // R5

    AST_VLD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_vld |=> !opnd_vld); // R5

    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy); // R9

    AST_REGS_STILL_OFF_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_vld |-> $stable(ar_bank)); // R7

    AST_PTR_STILL_OFF_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_vld |-> $stable(arp)); // R7

    AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd_vld && !lar_q) |->
            (ar_bank[DATA_W-1:9] == $past(ar_bank[DATA_W-1:9])) &&
            (ar_bank[2*DATA_W-1:DATA_W+9] == $past(ar_bank[2*DATA_W-1:DATA_W+9]))); // R6
endmodule

bind opnd_fetch opnd_fetch_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_rd   (mem_rd),
    .opnd_vld (opnd_vld),
    .ar_bank  (ar_bank),
    .arp      (arp),
    .lar_q    (lar_q)
);

// File: tb/opnd_fetch_tb_top.sv
`timescale 1ns/1ps
module opnd_fetch_tb_top;
    localparam int AW = 8;
    localparam int MEM_N = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [7:0]  issue_op = '0;
    logic        issue_lar = 1'b0, issue_tgt = 1'b0, issue_sx = 1'b0;
    logic [3:0]  issue_shift = '0;
    logic        issue_dp = 1'b0;
    logic        busy, mem_rd, opnd_vld, arp;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [31:0] opnd, ar_bank;

    logic [15:0] mem [MEM_N];
    logic [15:0] m_ar [2];
    logic        m_arp;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    opnd_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .issue_op(issue_op),
        .issue_lar(issue_lar), .issue_tgt(issue_tgt), .issue_sx(issue_sx),
        .issue_shift(issue_shift), .issue_dp(issue_dp), .busy(busy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .opnd(opnd), .opnd_vld(opnd_vld), .ar_bank(ar_bank), .arp(arp)
    );

    // synchronous data memory model: one cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext_shift(input logic [15:0] w, input logic sx, input logic [3:0] sh);
        logic [31:0] e;
        e = sx ? {{16{w[15]}}, w} : {16'h0, w};
        return e << sh;
    endfunction

    function automatic logic [15:0] step(input logic [15:0] r, input logic up, input logic dn);
        logic [8:0] lo;
        lo = r[8:0];
        if (up) lo = lo + 9'd1;
        if (dn) lo = lo - 9'd1;
        return {r[15:9], lo};
    endfunction

    // caller is at a negative edge; returns at a negative edge with the unit idle
    task automatic run_op(input logic [7:0] op, input logic lar, input logic tgt,
                          input logic sx, input logic [3:0] sh, input logic dp, input bit jam);
        logic [7:0]  ea;
        logic [15:0] w;
        logic [31:0] eo;
        ea = op[7] ? m_ar[m_arp][7:0] : {dp, op[6:0]};
        w  = mem[ea];
        eo = ext_shift(w, sx, sh);
        if (op[7] && !(lar && (tgt == m_arp))) m_ar[m_arp] = step(m_ar[m_arp], op[5], op[4]);
        if (lar) m_ar[tgt] = w;
        if (op[7] && !op[3]) m_arp = op[0];

        issue = 1'b1; issue_op = op; issue_lar = lar; issue_tgt = tgt;
        issue_sx = sx; issue_shift = sh; issue_dp = dp;
        @(negedge clk);
        if (jam) begin
            issue_op = ~op; issue_lar = ~lar; issue_tgt = ~tgt;
            issue_sx = ~sx; issue_shift = ~sh; issue_dp = ~dp;
        end else issue = 1'b0;
        chk("R9 busy after accept", {31'h0, busy}, 32'h1);
        chk(op[7] ? "R3 indirect address" : "R2 direct address", {24'h0, mem_addr}, {24'h0, ea});
        chk("R2 read strobe", {31'h0, mem_rd}, 32'h1);
        @(negedge clk);
        chk("R9 busy second cycle", {31'h0, busy}, 32'h1);
        chk("R5 no early valid", {31'h0, opnd_vld}, 32'h0);
        @(negedge clk);
        issue = 1'b0;
        chk("R5 valid pulse", {31'h0, opnd_vld}, 32'h1);
        chk(sx ? "R4 R5 sign-extended shifted operand" : "R4 R5 zero-extended shifted operand", opnd, eo);
        chk(lar ? "R8 register bank" : "R6 register bank", ar_bank, {m_ar[1], m_ar[0]});
        chk("R7 pointer", {31'h0, arp}, {31'h0, m_arp});
        chk("R9 idle after commit", {31'h0, busy}, 32'h0);
        if (jam) begin
            @(negedge clk);
            chk("R9 issue during busy ignored", {31'h0, opnd_vld | busy}, 32'h0);
            chk("R9 state untouched by ignored issue", ar_bank, {m_ar[1], m_ar[0]});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0F1E));
        for (int i = 0; i < MEM_N; i++) mem[i] = 16'($urandom());
        mem[8'h12] = 16'h8001;
        mem[8'h20] = 16'hA1FF;
        mem[8'h21] = 16'h3E00;
        mem[8'h40] = 16'h7FFF;
        mem[8'h41] = 16'h0140;
        m_ar[0] = '0; m_ar[1] = '0; m_arp = 1'b0;

        repeat (3) @(negedge clk);
        chk("R1 busy at reset", {31'h0, busy}, 32'h0);
        chk("R1 read strobe at reset", {31'h0, mem_rd}, 32'h0);
        chk("R1 valid at reset", {31'h0, opnd_vld}, 32'h0);
        chk("R1 operand at reset", opnd, 32'h0);
        chk("R1 registers at reset", ar_bank, 32'h0);
        chk("R1 pointer at reset", {31'h0, arp}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5: sign fill with largest shift, zero fill, direct page 1
        run_op(8'h12, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0);
        run_op(8'h12, 1'b0, 1'b0, 1'b0, 4'd4,  1'b0, 1'b0);
        run_op(8'h12, 1'b0, 1'b0, 1'b1, 4'd0,  1'b1, 1'b0);
        // R8: load register 0 directly with A1FF, register 1 with 3E00
        run_op(8'h20, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
        run_op(8'h21, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        // R6: increment wraps 1FF -> 000 keeping A000 upper bits, then decrement back
        run_op(8'hA8, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        run_op(8'h98, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);
        // R6: both step bits give no net change; R7 pointer reload to 1
        run_op(8'hB1, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0);
        // R6: decrement of register 1 wraps 000 -> 1FF keeping 3E upper bits
        run_op(8'h98, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
        // R8: collision, target equals pointer, load wins, pointer back to 0
        run_op(8'hA0, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0);
        // R8: no collision, register 0 steps, register 1 loaded
        run_op(8'hA8, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
        // R7: direct mode with bit 3 clear leaves pointer alone
        run_op(8'h41, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
        // R9: issue held high while busy
        run_op(8'h40, 1'b0, 1'b0, 1'b1, 4'd7, 1'b0, 1'b1);

        for (int n = 0; n < 400; n++) begin
            run_op(8'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                   4'($urandom()), 1'($urandom()), ($urandom() % 8) == 0);
            if (($urandom() % 4) == 0) @(negedge clk);
        end
        finish_run();
    end
endmodule